// File: doc/BRIEF.md
# Operate Instruction Execution Unit

This block executes the three register-to-register operate instructions of a small 16-bit processor: addition, bitwise AND and bitwise inversion. It holds eight 16-bit general registers and a three-flag condition state (negative, zero, positive). Each cycle it may receive one 16-bit instruction word qualified by a valid strobe. A recognised instruction reads one or two source registers and computes its result in the same cycle. The result and the new condition flags are committed on the next rising clock edge.

The second operand of ADD and AND is picked by bit 5 of the word. When bit 5 is clear, the operand is a register and bits 4 and 3 must be zero. When bit 5 is set, the operand is a 5-bit immediate in bits 4:0, sign-extended to 16 bits. Any word that is not a well-formed operate instruction raises an illegal indication and changes nothing. A combinational debug port reads any register, and the condition flags are visible at all times. The unit never touches memory and never alters program flow.

Top module: `opx_unit`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to 0x0000, sets the flags to zero-only ({neg,zero,pos} = 010), and holds `illegal` low.
- R2: ADD in register mode writes `R[w[11:9]] <= R[w[8:6]] + R[w[2:0]]`, wrapping modulo 2^16 with no carry or overflow indication. Here opcode `w[15:12]` = 0001, `w[5]` = 0 and `w[4:3]` = 00.
- R3: AND in register mode writes `R[w[11:9]] <= R[w[8:6]] & R[w[2:0]]`. Here opcode 0101, `w[5]` = 0 and `w[4:3]` = 00.
- R4: With `w[5]` = 1, ADD (0001) and AND (0101) use `w[4:0]` sign-extended to 16 bits as the second operand. The range is -16 to +15.
- R5: NOT (opcode 1001, with `w[5:0]` = 111111) writes `R[w[11:9]] <= ~R[w[8:6]]`.
- R6: Every write also sets exactly one flag from the 16-bit two's-complement result: neg if bit 15 is set, zero if the result is 0, pos otherwise.
- R7: A destination equal to a source register reads the old value and ends holding the new result.
- R8: A word with `instr_valid` high is illegal if any of these holds: the opcode is none of 0001/0101/1001; it is ADD or AND in register mode with `w[4:3]` not 00; or it is NOT with `w[5:0]` not 111111. An illegal word drives `illegal` high in the same cycle, and it changes no register and no flag.
- R9: While `instr_valid` is low, `illegal` stays low and no register or flag changes, whatever the instruction word.
- R10: `dbg_data` shows the register selected by `dbg_sel` combinationally.
- R11: The result of a legal instruction is visible on `dbg_data` and on the flags from the clock edge that ends its valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Qualifies `instr_word` for this cycle |
| instr_word | input | 16 | Instruction to execute |
| illegal | output | 1 | High while a valid but malformed or unknown word is presented |
| dbg_sel | input | 3 | Register index for the debug read |
| dbg_data | output | 16 | Contents of the selected register |
| cc_neg | output | 1 | Last written result was negative |
| cc_zero | output | 1 | Last written result was zero |
| cc_pos | output | 1 | Last written result was positive |

## Verification
The main function is driven by a single chained program whose results feed later sources. This tells apart register mode from immediate mode, and it separates immediates at both ends of the range (-16, -1, +15), which exposes a missing sign extension. Operands are chosen so that each of the three flags is produced. The program includes a wrap from 0xFFFF to 0x0000 and aliased source and destination, so a read-after-write mistake shows up. Malformed reserved bits, unknown opcodes and an idle strobe are each followed by a read-back of the register they name and of the flags, which proves nothing moved.

// File: rtl/opx_pkg.sv
package opx_pkg;

    localparam int WORD_W  = 16;
    localparam int REG_CNT = 8;
    localparam int REG_AW  = $clog2(REG_CNT);
    localparam int IMM_W   = 5;
    localparam int OPC_W   = 4;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

    typedef enum logic [1:0] {
        K_ADD  = 2'd0,
        K_AND  = 2'd1,
        K_NOT  = 2'd2,
        K_NONE = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic              legal;
        op_kind_e          kind;
        logic [REG_AW-1:0] dst;
        logic [REG_AW-1:0] src_a;
        logic [REG_AW-1:0] src_b;
        logic              use_imm;
        logic [WORD_W-1:0] imm;
    } dec_t;

    typedef struct packed {
        logic neg;
        logic zero;
        logic pos;
    } cc_t;

    localparam cc_t CC_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0};

    function automatic logic [WORD_W-1:0] sext_imm(input logic [IMM_W-1:0] f);
        return {{(WORD_W-IMM_W){f[IMM_W-1]}}, f};
    endfunction

    function automatic cc_t cc_from(input logic [WORD_W-1:0] v);
        cc_t c;
        c.neg  = v[WORD_W-1];
        c.zero = (v == '0);
        c.pos  = !v[WORD_W-1] && (v != '0);
        return c;
    endfunction

endpackage

// File: rtl/opx_decode.sv
module opx_decode
    import opx_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output dec_t              dec
);
    localparam int MODE_BIT = IMM_W;

    logic [OPC_W-1:0] opc;
    logic             reg_mode_ok;
    logic             not_ok;

    assign opc         = instr[WORD_W-1 -: OPC_W];
    assign reg_mode_ok = instr[MODE_BIT] || (instr[MODE_BIT-1:REG_AW] == '0);
    assign not_ok      = (instr[MODE_BIT:0] == '1);

    always_comb begin
        dec.dst     = instr[WORD_W-OPC_W-1 -: REG_AW];
        dec.src_a   = instr[WORD_W-OPC_W-REG_AW-1 -: REG_AW];
        dec.src_b   = instr[REG_AW-1:0];
        dec.use_imm = instr[MODE_BIT];
        dec.imm     = sext_imm(instr[IMM_W-1:0]);
        unique case (opc)
            OPC_ADD: begin dec.kind = K_ADD; dec.legal = reg_mode_ok; end
            OPC_AND: begin dec.kind = K_AND; dec.legal = reg_mode_ok; end
            OPC_NOT: begin dec.kind = K_NOT; dec.legal = not_ok;      end
            default: begin dec.kind = K_NONE; dec.legal = 1'b0;       end
        endcase
    end
endmodule

// File: rtl/opx_regfile.sv
module opx_regfile #(
    parameter int WIDTH = opx_pkg::WORD_W,
    parameter int DEPTH = opx_pkg::REG_CNT,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    input  logic [AW-1:0]    raddr_dbg,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b,
    output logic [WIDTH-1:0] rdata_dbg
);
    logic [WIDTH-1:0] store [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        localparam logic [AW-1:0] IDX = AW'(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                store[i] <= '0;
            end else if (we && (waddr == IDX)) begin
                store[i] <= wdata;
            end
        end
    end

    assign rdata_a   = store[raddr_a];
    assign rdata_b   = store[raddr_b];
    assign rdata_dbg = store[raddr_dbg];
endmodule

// File: rtl/opx_alu.sv
module opx_alu
    import opx_pkg::*;
(
    input  op_kind_e          kind,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] result
);
    always_comb begin
        unique case (kind)
            K_ADD:   result = op_a + op_b;
            K_AND:   result = op_a & op_b;
            K_NOT:   result = ~op_a;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/opx_unit.sv
module opx_unit
    import opx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr_word,
    output logic              illegal,
    input  logic [REG_AW-1:0] dbg_sel,
    output logic [WORD_W-1:0] dbg_data,
    output logic              cc_neg,
    output logic              cc_zero,
    output logic              cc_pos
);
    dec_t              dec;
    logic [WORD_W-1:0] src_a_val;
    logic [WORD_W-1:0] src_b_val;
    logic [WORD_W-1:0] op_b;
    logic [WORD_W-1:0] wb_data;
    logic [REG_AW-1:0] wb_dst;
    logic              wb_en;
    cc_t               cc_q;

    opx_decode u_dec (
        .instr (instr_word),
        .dec   (dec)
    );

    opx_regfile #(
        .WIDTH (WORD_W),
        .DEPTH (REG_CNT)
    ) u_rf (
        .clk       (clk),
        .rst       (rst),
        .we        (wb_en),
        .waddr     (wb_dst),
        .wdata     (wb_data),
        .raddr_a   (dec.src_a),
        .raddr_b   (dec.src_b),
        .raddr_dbg (dbg_sel),
        .rdata_a   (src_a_val),
        .rdata_b   (src_b_val),
        .rdata_dbg (dbg_data)
    );

    assign op_b = dec.use_imm ? dec.imm : src_b_val;

    opx_alu u_alu (
        .kind   (dec.kind),
        .op_a   (src_a_val),
        .op_b   (op_b),
        .result (wb_data)
    );

    assign wb_en   = instr_valid && dec.legal;
    assign wb_dst  = dec.dst;
    assign illegal = instr_valid && !dec.legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q <= CC_RESET;
        end else if (wb_en) begin
            cc_q <= cc_from(wb_data);
        end
    end

    assign cc_neg  = cc_q.neg;
    assign cc_zero = cc_q.zero;
    assign cc_pos  = cc_q.pos;
endmodule

// File: rtl/opx_unit_chk.sv
module opx_unit_chk
    import opx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic              illegal,
    input logic [REG_AW-1:0] dbg_sel,
    input logic [WORD_W-1:0] dbg_data,
    input logic              cc_neg,
    input logic              cc_zero,
    input logic              cc_pos,
    input logic              wb_en,
    input logic [REG_AW-1:0] wb_dst,
    input logic [WORD_W-1:0] wb_data
);
    assert_reset_flags_R1: assert property (@(posedge clk)
        rst |=> (cc_zero && !cc_neg && !cc_pos));

    assert_one_flag_R6: assert property (@(posedge clk) disable iff (rst)
        $countones({cc_neg, cc_zero, cc_pos}) == 1);

    assert_zero_result_R6: assert property (@(posedge clk) disable iff (rst)
        (wb_en && wb_data == '0) |=> cc_zero);

    assert_neg_result_R6: assert property (@(posedge clk) disable iff (rst)
        (wb_en && wb_data[WORD_W-1]) |=> cc_neg);

    assert_illegal_keeps_flags_R8: assert property (@(posedge clk) disable iff (rst)
        illegal |=> $stable({cc_neg, cc_zero, cc_pos}));

    assert_illegal_only_valid_R9: assert property (@(posedge clk) disable iff (rst)
        illegal |-> instr_valid);

    assert_idle_keeps_flags_R9: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable({cc_neg, cc_zero, cc_pos}));

    assert_result_visible_R11: assert property (@(posedge clk) disable iff (rst)
        (wb_en && wb_dst == dbg_sel) ##1 $stable(dbg_sel) |-> dbg_data == $past(wb_data));
endmodule

bind opx_unit opx_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .illegal     (illegal),
    .dbg_sel     (dbg_sel),
    .dbg_data    (dbg_data),
    .cc_neg      (cc_neg),
    .cc_zero     (cc_zero),
    .cc_pos      (cc_pos),
    .wb_en       (wb_en),
    .wb_dst      (wb_dst),
    .wb_data     (wb_data)
);

// File: tb/opx_unit_bench.sv
module opx_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = 16'h0000;
    logic        illegal;
    logic [2:0]  dbg_sel = 3'd0;
    logic [15:0] dbg_data;
    logic        cc_neg, cc_zero, cc_pos;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    opx_unit u_opx_unit (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .illegal     (illegal),
        .dbg_sel     (dbg_sel),
        .dbg_data    (dbg_data),
        .cc_neg      (cc_neg),
        .cc_zero     (cc_zero),
        .cc_pos      (cc_pos)
    );

    typedef struct packed {
        logic [15:0] iw;
        logic [2:0]  rchk;
        logic [15:0] val;
        logic [2:0]  cc;
        logic        ill;
        logic [7:0]  req;
    } vec_t;

    localparam int N_VEC = 17;
    // flags are {neg,zero,pos}
    localparam vec_t VECS [N_VEC] = '{
        '{16'h1225, 3'd1, 16'h0005, 3'b001, 1'b0, 8'd4}, // R4 ADD R1,R0,#5
        '{16'h143F, 3'd2, 16'hFFFF, 3'b100, 1'b0, 8'd4}, // R4 ADD R2,R0,#-1
        '{16'h1642, 3'd3, 16'h0004, 3'b001, 1'b0, 8'd2}, // R2 ADD R3,R1,R2 wraps
        '{16'h58B0, 3'd4, 16'hFFF0, 3'b100, 1'b0, 8'd4}, // R4 AND R4,R2,#-16
        '{16'h5A44, 3'd5, 16'h0000, 3'b010, 1'b0, 8'd3}, // R3 AND R5,R1,R4
        '{16'h9CFF, 3'd6, 16'hFFFB, 3'b100, 1'b0, 8'd5}, // R5 NOT R6,R3
        '{16'h9DBF, 3'd6, 16'h0004, 3'b001, 1'b0, 8'd7}, // R7 NOT R6,R6
        '{16'h1241, 3'd1, 16'h000A, 3'b001, 1'b0, 8'd7}, // R7 ADD R1,R1,R1
        '{16'h1EA1, 3'd7, 16'h0000, 3'b010, 1'b0, 8'd6}, // R6 ADD R7,R2,#1 wraps to 0
        '{16'h1F2F, 3'd7, 16'hFFFF, 3'b100, 1'b0, 8'd4}, // R4 ADD R7,R4,#15
        '{16'h50AF, 3'd0, 16'h000F, 3'b001, 1'b0, 8'd4}, // R4 AND R0,R2,#15
        '{16'h16F0, 3'd3, 16'hFFF4, 3'b100, 1'b0, 8'd4}, // R4 ADD R3,R3,#-16
        '{16'h120A, 3'd1, 16'h000A, 3'b100, 1'b1, 8'd8}, // R8 ADD reg, bit3 set
        '{16'h907E, 3'd0, 16'h000F, 3'b100, 1'b1, 8'd8}, // R8 NOT low bits 111110
        '{16'h2200, 3'd1, 16'h000A, 3'b100, 1'b1, 8'd8}, // R8 opcode 0010
        '{16'hD000, 3'd0, 16'h000F, 3'b100, 1'b1, 8'd8}, // R8 opcode 1101
        '{16'h5051, 3'd0, 16'h000F, 3'b100, 1'b1, 8'd8}  // R8 AND reg, bit4 set
    };

    localparam logic [15:0] FINAL_REGS [8] = '{
        16'h000F, 16'h000A, 16'hFFFF, 16'hFFF4,
        16'hFFF0, 16'h0000, 16'h0004, 16'hFFFF
    };

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] iw, input logic vld, output logic ill_seen);
        @(negedge clk);
        instr_word  = iw;
        instr_valid = vld;
        #1 ill_seen = illegal;
        @(negedge clk);
        instr_valid = 1'b0;
        instr_word  = 16'h0000;
    endtask

    task automatic read_reg(input logic [2:0] idx, output logic [15:0] v);
        dbg_sel = idx;
        #1 v = dbg_data;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_cleared(input string tag);
        logic [15:0] v;
        for (int i = 0; i < 8; i++) begin
            read_reg(3'(i), v);
            check($sformatf("%s reg %0d cleared", tag, i), v, 16'h0000);
        end
        check($sformatf("%s flags zero-only", tag), {13'd0, cc_neg, cc_zero, cc_pos}, 16'h0002);
        check($sformatf("%s illegal low", tag), {15'd0, illegal}, 16'h0000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic        ill;
        logic [15:0] v;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 check_cleared("R1 power-on");

        // Vector walk: R2 R3 R4 R5 R6 R7 R8 R10 R11
        for (int k = 0; k < N_VEC; k++) begin
            issue(VECS[k].iw, 1'b1, ill);
            check($sformatf("R%0d vec %0d illegal flag", VECS[k].req, k),
                  {15'd0, ill}, {15'd0, VECS[k].ill});
            read_reg(VECS[k].rchk, v);
            check($sformatf("R%0d vec %0d reg %0d value", VECS[k].req, k, VECS[k].rchk),
                  v, VECS[k].val);
            check($sformatf("R6 vec %0d flags", k),
                  {13'd0, cc_neg, cc_zero, cc_pos}, {13'd0, VECS[k].cc});
        end

        // R10: every register readable through the debug port
        for (int i = 0; i < 8; i++) begin
            read_reg(3'(i), v);
            check($sformatf("R10 final reg %0d", i), v, FINAL_REGS[i]);
        end

        // R9: a legal word with the strobe low does nothing
        issue(16'h1225, 1'b0, ill);  // ADD R1,R0,#5 without valid
        check("R9 idle legal word illegal", {15'd0, ill}, 16'h0000);
        read_reg(3'd1, v);
        check("R9 idle legal word reg 1", v, 16'h000A);
        check("R9 idle legal word flags", {13'd0, cc_neg, cc_zero, cc_pos}, 16'h0004);

        // R9: an unknown opcode with the strobe low raises nothing
        issue(16'hF0FF, 1'b0, ill);
        check("R9 idle bad word illegal", {15'd0, ill}, 16'h0000);
        read_reg(3'd0, v);
        check("R9 idle bad word reg 0", v, 16'h000F);

        // R11: result visible right after one edge, flags follow
        issue(16'h1E21, 1'b1, ill);  // ADD R7,R0,#1 -> 0x0010
        read_reg(3'd7, v);
        check("R11 next-edge result", v, 16'h0010);
        check("R11 next-edge flags", {13'd0, cc_neg, cc_zero, cc_pos}, 16'h0001);

        // R1: reset in the middle of operation clears everything again
        apply_reset();
        #1 check_cleared("R1 mid-run");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule